// File: doc/BRIEF.md
# Ridge Orientation Resonance Engine

This block picks the dominant ridge direction of one fingerprint image block. An upstream unit rotates a 24x24 pixel analysis window around each 8x8 pixel block and sums the pixels along each rotated row. For every one of 16 orientations, 11.25 degrees apart, it delivers one row-sum vector of 24 unsigned sums. The block correlates each vector with cosine and sine waves at four spatial frequencies. Those frequencies match ridge/valley widths of 12, 6, 3 and 1.5 pixels. The two correlations are combined into a resonance energy, and the block tracks the strongest (orientation, frequency) pair over the whole block.

Samples arrive one per accepted cycle on a valid/ready stream. Each vector is opened by a start marker and tagged with its orientation. After the 16th vector the block pulses a result carrying the winning orientation, the winning frequency, the peak energy and a flag that tells whether the block's input sequence was well formed. It then starts the next block from a cleared maximum.

Top module: `ridge_orient_dft`

## Requirements
- R1: A sample is taken on every clock edge where in_valid and in_ready are both high. After each 24th sample of a vector, in_ready is low for exactly one cycle. At all other times after reset it is high.
- R2: Sample n (0..23) of a vector is weighted by round(16384*cos(2*pi*k*n/24)) and round(16384*sin(2*pi*k*n/24)), where frequency index f selects k = 2, 4, 8, 16 for f = 0, 1, 2, 3. The energy is the cosine sum squared plus the sine sum squared, exact to the integer.
- R3: Full-scale sums (8191) yield exact energies with no wrap in any accumulator or in the energy.
- R4: The result reports the vector position in the block (0..15) and the frequency index of the largest energy, together with that energy.
- R5: A candidate replaces the held maximum only when it is strictly greater, so ties keep the lower orientation and then the lower frequency. A block whose energies are all zero reports orientation 0, frequency 0 and energy 0.
- R6: Frequency index 3 aliases index 2 over 24 samples and always gives an equal energy, so index 2 is reported in its place.
- R7: res_valid is high for one cycle, on the cycle right after the stall that follows the 16th vector. The result fields hold their values between pulses.
- R8: The running maximum is cleared after each result, so a block never reports an energy from an earlier block.
- R9: The first sample of each vector must carry in_sov and an in_orient equal to the vector's position in the block, and no other sample may carry in_sov. A breach sets err_sticky until reset and drives res_ok low in that block's result. A later clean block reports res_ok high.
- R10: In reset: in_ready high, res_valid, res_ok, err_sticky low, result fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Row-sum sample present |
| in_ready | output | 1 | Block can take a sample |
| in_sov | input | 1 | Marks the first sample of a vector |
| in_orient | input | 4 | Orientation tag of the vector |
| in_sample | input | SAMPLE_W (13) | Unsigned row sum |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | Block input sequence was well formed |
| res_orient | output | 4 | Winning orientation |
| res_freq | output | 2 | Winning frequency index |
| res_energy | output | 2*(SAMPLE_W+21)+1 (69) | Peak resonance energy |
| err_sticky | output | 1 | A sequence error has occurred since reset |

## Verification
in_ready falls one cycle after the edge that takes a vector's 24th sample and rises again one edge later. That second edge evaluates the vector, so after the 16th vector res_valid and its fields appear on the edge after the stall. A reference model in the bench advances on every rising edge using the inputs held steady since the previous falling edge. At each falling edge it compares in_ready, res_valid and err_sticky, and also the result fields whenever a pulse is due. Directed blocks add hand-known winners at fixed points: a full-scale square wave, equal-energy ties, an all-zero block, and broken sequences.

// File: rtl/odft_pkg.sv
// Shared constants, types and coefficient functions for the ridge
// orientation resonance engine. Assumes a 24-sample window so that a
// quarter period of the reference waves is a whole number of samples.
package odft_pkg;
    localparam int WIN_LEN    = 24;
    localparam int NUM_FREQ   = 4;
    localparam int NUM_ORIENT = 16;
    localparam int COEF_W     = 16;
    localparam int IDX_W      = $clog2(WIN_LEN);
    localparam int ORIENT_W   = $clog2(NUM_ORIENT);
    localparam int FREQ_W     = $clog2(NUM_FREQ);
    localparam int QTR        = WIN_LEN / 4;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [IDX_W-1:0]         phase_t;

    // Q1.14 cosine of q*15 degrees for q in 0..QTR
    function automatic coef_t quarter_wave(input phase_t q);
        case (q)
            5'd0:    quarter_wave = 16'sd16384;
            5'd1:    quarter_wave = 16'sd15826;
            5'd2:    quarter_wave = 16'sd14189;
            5'd3:    quarter_wave = 16'sd11585;
            5'd4:    quarter_wave = 16'sd8192;
            5'd5:    quarter_wave = 16'sd4240;
            default: quarter_wave = 16'sd0;
        endcase
    endfunction

    // Q1.14 cosine at phase p (0..WIN_LEN-1) by quadrant folding
    function automatic coef_t cos_q14(input phase_t p);
        if (p <= phase_t'(QTR))
            cos_q14 = quarter_wave(p);
        else if (p <= phase_t'(2*QTR))
            cos_q14 = -quarter_wave(phase_t'(2*QTR) - p);
        else if (p <= phase_t'(3*QTR))
            cos_q14 = -quarter_wave(p - phase_t'(2*QTR));
        else
            cos_q14 = quarter_wave(phase_t'(WIN_LEN) - p);
    endfunction

    // Q1.14 sine at phase p, a quarter period behind the cosine
    function automatic coef_t sin_q14(input phase_t p);
        sin_q14 = cos_q14((p >= phase_t'(QTR)) ? p - phase_t'(QTR) : p + phase_t'(3*QTR));
    endfunction

    // Phase advance per sample for frequency index f (2, 4, 8, 16 cycles)
    function automatic phase_t freq_step(input int f);
        freq_step = phase_t'(2 << f);
    endfunction
endpackage

// File: rtl/odft_corr_bank.sv
// Correlation bank: one cosine and one sine accumulator per frequency.
// Each frequency keeps its own phase register that advances by its step
// per taken sample, so no multiply is needed for the table index.
// Assumes clear and take are never high together.
module odft_corr_bank
    import odft_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int ACC_W    = 34
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       clear,
    input  logic [SAMPLE_W-1:0]        sample,
    output logic signed [ACC_W-1:0]    acc_cos [NUM_FREQ],
    output logic signed [ACC_W-1:0]    acc_sin [NUM_FREQ]
);
    logic signed [ACC_W-1:0] samp_ext;

    // Zero-extend the unsigned sample into the signed accumulator width
    assign samp_ext = ACC_W'($signed({1'b0, sample}));

    for (genvar f = 0; f < NUM_FREQ; f++) begin : g_freq
        localparam phase_t STEP = freq_step(f);
        phase_t                  phase_q;
        coef_t                   c_coef, s_coef;
        logic signed [ACC_W-1:0] c_ext, s_ext, c_acc_q, s_acc_q;

        // Look up the reference wave values at the current phase
        always_comb begin
            c_coef = cos_q14(phase_q);
            s_coef = sin_q14(phase_q);
            c_ext  = ACC_W'(c_coef);
            s_ext  = ACC_W'(s_coef);
        end

        // Advance the phase and accumulate the weighted sample
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                phase_q <= '0;
                c_acc_q <= '0;
                s_acc_q <= '0;
            end else if (take) begin
                phase_q <= (phase_q >= phase_t'(WIN_LEN) - STEP) ?
                           phase_q + STEP - phase_t'(WIN_LEN) : phase_q + STEP;
                c_acc_q <= c_acc_q + samp_ext * c_ext;
                s_acc_q <= s_acc_q + samp_ext * s_ext;
            end
        end

        assign acc_cos[f] = c_acc_q;
        assign acc_sin[f] = s_acc_q;
    end
endmodule

// File: rtl/odft_energy.sv
// Energy stage: squares and adds the cosine and sine sums per frequency.
// Purely combinational; assumes EN_W >= 2*ACC_W+1 so no sum can wrap.
module odft_energy
    import odft_pkg::*;
#(
    parameter int ACC_W = 34,
    parameter int EN_W  = 69
) (
    input  logic signed [ACC_W-1:0] acc_cos [NUM_FREQ],
    input  logic signed [ACC_W-1:0] acc_sin [NUM_FREQ],
    output logic [EN_W-1:0]         energy  [NUM_FREQ]
);
    for (genvar f = 0; f < NUM_FREQ; f++) begin : g_sq
        logic signed [EN_W-1:0] c_wide, s_wide;

        // Sign-extend before squaring so the product keeps every bit
        assign c_wide    = EN_W'(acc_cos[f]);
        assign s_wide    = EN_W'(acc_sin[f]);
        assign energy[f] = $unsigned(c_wide * c_wide + s_wide * s_wide);
    end
endmodule

// File: rtl/odft_peak.sv
// Peak tracker: folds one vector's energies into the running maximum,
// strictly-greater only, scanning frequencies from low to high. On the
// last vector of a block it registers the result and clears the maximum.
module odft_peak
    import odft_pkg::*;
#(
    parameter int EN_W = 69
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eval,
    input  logic                last,
    input  logic                block_ok,
    input  logic [ORIENT_W-1:0] orient,
    input  logic [EN_W-1:0]     energy [NUM_FREQ],
    output logic                res_valid,
    output logic                res_ok,
    output logic [ORIENT_W-1:0] res_orient,
    output logic [FREQ_W-1:0]   res_freq,
    output logic [EN_W-1:0]     res_energy
);
    logic [EN_W-1:0]     run_e, best_e;
    logic [ORIENT_W-1:0] run_o, best_o;
    logic [FREQ_W-1:0]   run_f, best_f;

    // Compare this vector's energies against the held maximum
    always_comb begin
        best_e = run_e;
        best_o = run_o;
        best_f = run_f;
        for (int f = 0; f < NUM_FREQ; f++) begin
            if (energy[f] > best_e) begin
                best_e = energy[f];
                best_o = orient;
                best_f = FREQ_W'(f);
            end
        end
    end

    // Hold the running maximum and publish it at the end of a block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_e      <= '0;
            run_o      <= '0;
            run_f      <= '0;
            res_valid  <= 1'b0;
            res_ok     <= 1'b0;
            res_orient <= '0;
            res_freq   <= '0;
            res_energy <= '0;
        end else begin
            res_valid <= 1'b0;
            if (eval) begin
                if (last) begin
                    res_valid  <= 1'b1;
                    res_ok     <= block_ok;
                    res_orient <= best_o;
                    res_freq   <= best_f;
                    res_energy <= best_e;
                    run_e      <= '0;
                    run_o      <= '0;
                    run_f      <= '0;
                end else begin
                    run_e <= best_e;
                    run_o <= best_o;
                    run_f <= best_f;
                end
            end
        end
    end
endmodule

// File: rtl/ridge_orient_dft.sv
// Top of the ridge orientation resonance engine. Counts samples and
// vectors, checks the start marker and orientation tag, stalls the input
// for one evaluation cycle after each vector, and ties the correlation,
// energy and peak stages together. Assumes samples are unsigned row sums.
module ridge_orient_dft
    import odft_pkg::*;
#(
    parameter int SAMPLE_W = 13
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic                                  in_sov,
    input  logic [ORIENT_W-1:0]                   in_orient,
    input  logic [SAMPLE_W-1:0]                   in_sample,
    output logic                                  res_valid,
    output logic                                  res_ok,
    output logic [ORIENT_W-1:0]                   res_orient,
    output logic [FREQ_W-1:0]                     res_freq,
    output logic [2*(SAMPLE_W+COEF_W+IDX_W):0]    res_energy,
    output logic                                  err_sticky
);
    localparam int ACC_W = SAMPLE_W + COEF_W + IDX_W;
    localparam int EN_W  = 2 * ACC_W + 1;

    logic [IDX_W-1:0]        idx_q;
    logic [ORIENT_W-1:0]     vec_q;
    logic                    eval_q, bad_q, err_q;
    logic                    take, seq_fault, last_sample, last_vec;
    logic signed [ACC_W-1:0] acc_cos [NUM_FREQ];
    logic signed [ACC_W-1:0] acc_sin [NUM_FREQ];
    logic [EN_W-1:0]         energy  [NUM_FREQ];

    // Handshake and sequence decode for the sample on the input
    always_comb begin
        in_ready    = !eval_q;
        take        = in_valid && in_ready;
        last_sample = (idx_q == IDX_W'(WIN_LEN - 1));
        last_vec    = (vec_q == ORIENT_W'(NUM_ORIENT - 1));
        seq_fault   = take && ((idx_q == '0) ? (!in_sov || in_orient != vec_q) : in_sov);
    end

    // Sample/vector counters, evaluation stall and error bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            vec_q  <= '0;
            eval_q <= 1'b0;
            bad_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (take) begin
                idx_q <= last_sample ? '0 : idx_q + 1'b1;
                if (last_sample) eval_q <= 1'b1;
            end
            if (eval_q) begin
                eval_q <= 1'b0;
                vec_q  <= last_vec ? '0 : vec_q + 1'b1;
                if (last_vec) bad_q <= 1'b0;
            end
            if (seq_fault) begin
                bad_q <= 1'b1;
                err_q <= 1'b1;
            end
        end
    end

    assign err_sticky = err_q;

    odft_corr_bank #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_corr (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .clear   (eval_q),
        .sample  (in_sample),
        .acc_cos (acc_cos),
        .acc_sin (acc_sin)
    );

    odft_energy #(.ACC_W(ACC_W), .EN_W(EN_W)) u_energy (
        .acc_cos (acc_cos),
        .acc_sin (acc_sin),
        .energy  (energy)
    );

    odft_peak #(.EN_W(EN_W)) u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval       (eval_q),
        .last       (last_vec),
        .block_ok   (!bad_q),
        .orient     (vec_q),
        .energy     (energy),
        .res_valid  (res_valid),
        .res_ok     (res_ok),
        .res_orient (res_orient),
        .res_freq   (res_freq),
        .res_energy (res_energy)
    );
endmodule

// File: rtl/odft_checker.sv
// Property checker for the ridge orientation resonance engine, bound to
// the top module. Observes ports only.
module odft_checker
    import odft_pkg::*;
#(
    parameter int EN_W = 69
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_ready,
    input logic                res_valid,
    input logic                res_ok,
    input logic [ORIENT_W-1:0] res_orient,
    input logic [FREQ_W-1:0]   res_freq,
    input logic [EN_W-1:0]     res_energy,
    input logic                err_sticky
);
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready); // R1

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R7

    AST_RESULT_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(!in_ready)); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_orient) && $stable(res_freq) && $stable(res_energy) && $stable(res_ok))); // R7

    AST_ZERO_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_energy == '0) |-> (res_orient == '0 && res_freq == '0)); // R5

    AST_ALIAS_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_freq != FREQ_W'(NUM_FREQ - 1))); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R9

    AST_CLEAN_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !err_sticky) |-> res_ok); // R9
endmodule

bind ridge_orient_dft odft_checker #(.EN_W(EN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .res_valid  (res_valid),
    .res_ok     (res_ok),
    .res_orient (res_orient),
    .res_freq   (res_freq),
    .res_energy (res_energy),
    .err_sticky (err_sticky)
);

// File: tb/tb_ridge_orient_dft.sv
`timescale 1ns/1ps
module tb_ridge_orient_dft;
    localparam int SAMPLE_W = 13;
    localparam int EN_W     = 2 * (SAMPLE_W + 16 + 5) + 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_sov = 1'b0;
    logic [3:0]          in_orient = '0;
    logic [SAMPLE_W-1:0] in_sample = '0;
    logic                in_ready, res_valid, res_ok, err_sticky;
    logic [3:0]          res_orient;
    logic [1:0]          res_freq;
    logic [EN_W-1:0]     res_energy;

    ridge_orient_dft #(.SAMPLE_W(SAMPLE_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sov(in_sov), .in_orient(in_orient), .in_sample(in_sample),
        .res_valid(res_valid), .res_ok(res_ok), .res_orient(res_orient),
        .res_freq(res_freq), .res_energy(res_energy), .err_sticky(err_sticky)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // ---------------- reference model ----------------
    int            coef_c [4][24];
    int            coef_s [4][24];
    int            smp [24];
    int            m_idx, m_vec, m_pend, m_bad, m_err;
    logic [127:0]  best_e;
    int            best_o, best_f;
    logic          e_ready, e_rv, e_ok;
    int            e_o, e_f;
    logic [127:0]  e_e;

    initial begin
        for (int f = 0; f < 4; f++) begin
            for (int n = 0; n < 24; n++) begin
                real ang;
                ang = 2.0 * 3.14159265358979 * real'(2 << f) * real'(n) / 24.0;
                coef_c[f][n] = int'(16384.0 * $cos(ang));
                coef_s[f][n] = int'(16384.0 * $sin(ang));
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_vec = 0; m_pend = 0; m_bad = 0; m_err = 0;
            best_e = '0; best_o = 0; best_f = 0;
            e_ready = 1'b1; e_rv = 1'b0; e_ok = 1'b0; e_o = 0; e_f = 0; e_e = '0;
        end else begin
            e_rv = 1'b0;
            if (m_pend != 0) begin
                for (int f = 0; f < 4; f++) begin
                    longint c, s;
                    logic signed [127:0] cw, sw;
                    logic [127:0] en;
                    c = 0; s = 0;
                    for (int n = 0; n < 24; n++) begin
                        c += longint'(smp[n]) * longint'(coef_c[f][n]);
                        s += longint'(smp[n]) * longint'(coef_s[f][n]);
                    end
                    cw = c; sw = s;
                    en = cw * cw + sw * sw;
                    if (en > best_e) begin best_e = en; best_o = m_vec; best_f = f; end
                end
                if (m_vec == 15) begin
                    e_rv = 1'b1; e_o = best_o; e_f = best_f; e_e = best_e; e_ok = (m_bad == 0);
                    best_e = '0; best_o = 0; best_f = 0; m_bad = 0;
                end
                m_vec = (m_vec + 1) % 16;
                m_pend = 0;
            end else if (in_valid) begin
                if ((m_idx == 0 && (!in_sov || int'(in_orient) != m_vec)) || (m_idx != 0 && in_sov)) begin
                    m_bad = 1; m_err = 1;
                end
                smp[m_idx] = int'(in_sample);
                m_idx++;
                if (m_idx == 24) begin m_idx = 0; m_pend = 1; end
            end
            e_ready = (m_pend == 0);
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and compare against the model
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk("R1", "in_ready", 128'(in_ready), 128'(e_ready));
            chk("R7", "res_valid", 128'(res_valid), 128'(e_rv));
            chk("R9", "err_sticky", 128'(err_sticky), 128'(m_err));
            if (e_rv) begin
                chk("R4", "res_orient", 128'(res_orient), 128'(e_o));
                chk("R4", "res_freq", 128'(res_freq), 128'(e_f));
                chk("R2", "res_energy", 128'(res_energy), e_e);
                chk("R9", "res_ok", 128'(res_ok), 128'(e_ok));
            end
        end
    endtask

    int pat [24];

    task automatic fill(input int kind, input int v);
        for (int n = 0; n < 24; n++) begin
            case (kind)
                1: pat[n] = (v == 5) ? (((n % 12) < 6) ? 8191 : 0) : 0;
                2: pat[n] = (v == 3 || v == 9) ? (((n % 3) == 0) ? 8191 : 0) : 0;
                3: pat[n] = 0;
                default: pat[n] = int'($urandom_range(0, 8191));
            endcase
        end
    endtask

    task automatic send_vec(input int orient, input bit sov_first, input int stray);
        logic acc;
        for (int n = 0; n < 24; n++) begin
            if ($urandom_range(0, 3) == 0) begin in_valid = 1'b0; step(); end
            in_valid  = 1'b1;
            in_sov    = (n == 0) ? sov_first : (n == stray);
            in_orient = 4'(orient);
            in_sample = SAMPLE_W'(pat[n]);
            do begin acc = in_ready; step(); end while (!acc);
        end
        in_valid = 1'b0;
        in_sov   = 1'b0;
    endtask

    // kind: 0 random, 1 square at v5, 2 ties, 3 zeros, 4 bad tag, 5 stray marker
    task automatic run_block(input int kind);
        for (int v = 0; v < 16; v++) begin
            fill((kind >= 4) ? 0 : kind, v);
            send_vec((kind == 4 && v == 7) ? 8 : v, 1'b1, (kind == 5 && v == 2) ? 10 : -1);
        end
        step();
        chk("R7", "pulse after stall", 128'(res_valid), 128'(1));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10", "in_ready", 128'(in_ready), 128'(1));
        chk("R10", "res_valid", 128'(res_valid), 128'(0));
        chk("R10", "err_sticky", 128'(err_sticky), 128'(0));
        chk("R10", "res_ok", 128'(res_ok), 128'(0));
        chk("R10", "result fields", 128'({res_orient, res_freq, res_energy}), 128'(0));
        rst_n = 1'b1;
        step();

        run_block(0);                                     // R2 R4 random data
        chk("R4", "ok clean", 128'(res_ok), 128'(1));
        step();
        chk("R7", "held orient", 128'(res_orient), 128'(e_o));

        run_block(1);                                     // R3 R8 full-scale square
        chk("R8", "orient after clear", 128'(res_orient), 128'(5));
        chk("R3", "freq of square", 128'(res_freq), 128'(0));
        chk("R3", "energy nonzero", 128'(res_energy != 0), 128'(1));

        run_block(2);                                     // R5 R6 ties
        chk("R5", "tie lower orient", 128'(res_orient), 128'(3));
        chk("R6", "alias gives freq 2", 128'(res_freq), 128'(2));

        run_block(3);                                     // R5 all zero
        chk("R5", "zero block", 128'({res_orient, res_freq, res_energy}), 128'(0));

        chk("R9", "no error yet", 128'(err_sticky), 128'(0));
        run_block(4);                                     // R9 tag out of order
        chk("R9", "bad tag ok low", 128'(res_ok), 128'(0));
        chk("R9", "err set", 128'(err_sticky), 128'(1));

        run_block(0);                                     // R9 recovery
        chk("R9", "clean after error", 128'(res_ok), 128'(1));
        chk("R9", "err held", 128'(err_sticky), 128'(1));

        run_block(5);                                     // R9 stray marker
        chk("R9", "stray marker ok low", 128'(res_ok), 128'(0));

        repeat (3) step();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #1000000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule